// File: doc/BRIEF.md
# Serially Addressed Dual-Port GPIO Expander

This block is a slave on a four-wire serial bus that controls two 8-bit general-purpose ports through a small register file. The bus runs in clock mode 0: the master drives data while the serial clock is low, and the slave samples on the rising edge. Several copies of the block can share one chip select line. A 3-bit device number inside the first byte of each frame picks the copy that responds. Each copy compares that number with three strap inputs, but only after its own configuration register has turned address matching on. Until then, every copy answers to device number zero. So a single write to device zero can switch matching on in all copies at once.

A frame is always three bytes, most significant bit first. The first byte is the opcode, the second is the register address, and the third is the data. On a read, the selected copy drives the register contents onto the serial output during the third byte. Each port has a direction register and an output latch. A direction bit of 0 turns the matching pin into an output that drives its latch bit. A direction bit of 1 leaves the pin as an input. Reading a port register returns the levels seen on the pins. Bus and pin inputs are resynchronised to the system clock, so the serial clock must stay well below the system clock rate.

Top module: `spi_gpio_expander`

## Requirements
- R1: After reset both direction registers read 0xFF, both output latches hold 0x00, the configuration register reads 0x00, every pin output enable is low and the serial output is not driven.
- R2: The opcode byte is 0100 in its upper four bits, the device number in bits 3:1 and the access type in bit 0 (1 = read, 0 = write); a frame whose upper four bits differ changes nothing and drives nothing.
- R3: A frame is opcode, register address, data, each most significant bit first, sampled on rising serial clock edges; a write of a complete frame updates the addressed register and a later read returns that value in the third byte.
- R4: Register 0x00/0x01 is the direction of port A/B and 0x12/0x13 its output latch; port A is bits 7:0 and port B bits 15:8 of the pin vectors; a pin's output enable is high exactly when its direction bit is 0, and its output value is its latch bit.
- R5: A read of 0x12 or 0x13 returns the pin levels of that port, which are the latch bits on output pins and the external levels on input pins.
- R6: While the address-match bit is clear, only frames with device number 000 are accepted, whatever the strap inputs are.
- R7: The address-match bit is bit 3 of the configuration register at 0x0B; while it is set, only frames whose device number equals the strap inputs are accepted.
- R8: Raising chip select before the 24th rising serial clock edge aborts the frame; no register changes.
- R9: The serial output enable stays low for every frame that is not accepted and whenever chip select is high.
- R10: Reads of any address other than 0x00, 0x01, 0x0B, 0x12 and 0x13 return 0x00, and writes to them change nothing; configuration bits other than bit 3 read 0 and have no effect.
- R11: The serial output is driven only on an accepted read, from the first bit of the third byte until chip select rises, and never during a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sclk | input | 1 | Serial clock from the master, idle low |
| spi_cs_n | input | 1 | Shared active-low chip select |
| spi_mosi | input | 1 | Serial data from the master |
| spi_miso | output | 1 | Serial data to the master, valid while spi_miso_oe is high |
| spi_miso_oe | output | 1 | Output enable of the serial data pad |
| hw_addr | input | 3 | Strap inputs giving this copy's device number |
| gpio_in | input | 8*NUM_PORTS | Pin levels; port A in bits 7:0 |
| gpio_out | output | 8*NUM_PORTS | Output latch value for each pin |
| gpio_oe | output | 8*NUM_PORTS | Pin output enable, high drives the pin |

## Verification
The bench builds the block with its default two ports and a two-stage synchroniser. It runs the serial clock at six system clocks per half period. That configuration is small enough to sweep all 64 pairs of strap value and device number with matching enabled, and all eight device numbers with matching disabled. The bench also takes each port through several direction and latch patterns against a mix of external pin levels. A model in the bench predicts every register readback, the serial output enable bit by bit, and the pin drive, including frames aborted after 8, 16 and 23 bits.

// File: rtl/spi_gpio_pkg.sv
package spi_gpio_pkg;
  localparam int BYTE_W      = 8;
  localparam int DEV_W       = 3;
  localparam int FRAME_BYTES = 3;
  localparam int FRAME_BITS  = FRAME_BYTES * BYTE_W;
  localparam int CNT_W       = $clog2(FRAME_BITS + 1);

  localparam logic [3:0]        OP_PREFIX     = 4'b0100;
  localparam logic [BYTE_W-1:0] REG_DIR_BASE  = 8'h00;
  localparam logic [BYTE_W-1:0] REG_CFG       = 8'h0B;
  localparam logic [BYTE_W-1:0] REG_PIN_BASE  = 8'h12;
  localparam int                CFG_MATCH_BIT = 3;

  typedef struct packed {
    logic [3:0]       prefix;
    logic [DEV_W-1:0] dev;
    logic             rd;
  } opcode_t;
endpackage

// File: rtl/spi_gpio_sync.sv
module spi_gpio_sync #(
  parameter int               WIDTH   = 1,
  parameter int               STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [STAGES-1:0][WIDTH-1:0] pipe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe <= {STAGES{RST_VAL}};
    else        pipe <= {pipe[STAGES-2:0], d};
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/spi_gpio_frame.sv
module spi_gpio_frame
  import spi_gpio_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk_s,
  input  logic              cs_n_s,
  input  logic              mosi_s,
  input  logic [DEV_W-1:0]  hw_addr,
  input  logic              haen,
  input  logic [BYTE_W-1:0] rd_data,
  output logic              cs_act,
  output logic [BYTE_W-1:0] reg_addr,
  output logic [BYTE_W-1:0] wr_data,
  output logic              commit_wr,
  output logic [DEV_W-1:0]  op_dev,
  output logic              miso,
  output logic              miso_oe
);
  localparam logic [CNT_W-1:0] OP_LAST   = CNT_W'(BYTE_W - 1);
  localparam logic [CNT_W-1:0] ADDR_LAST = CNT_W'(2 * BYTE_W - 1);
  localparam logic [CNT_W-1:0] DATA_LAST = CNT_W'(FRAME_BITS - 1);
  localparam logic [CNT_W-1:0] FRAME_END = CNT_W'(FRAME_BITS);
  localparam logic [CNT_W-1:0] SHIFT_MIN = CNT_W'(2 * BYTE_W);

  logic              sclk_q;
  logic              rise, fall;
  logic [BYTE_W-2:0] shreg;
  logic [BYTE_W-1:0] byte_now;
  opcode_t           op_now;
  logic              op_match;
  logic [CNT_W-1:0]  bit_cnt;
  logic              sel_q, rd_q, load_pend;
  logic [BYTE_W-1:0] out_sh;

  assign cs_act   = ~cs_n_s;
  assign rise     = sclk_s & ~sclk_q;
  assign fall     = ~sclk_s & sclk_q;
  assign byte_now = {shreg, mosi_s};
  assign op_now   = opcode_t'(byte_now);
  assign op_match = (op_now.prefix == OP_PREFIX) &&
                    (op_now.dev == (haen ? hw_addr : {DEV_W{1'b0}}));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q    <= 1'b0;
      shreg     <= '0;
      bit_cnt   <= '0;
      sel_q     <= 1'b0;
      rd_q      <= 1'b0;
      load_pend <= 1'b0;
      op_dev    <= '0;
      reg_addr  <= '0;
      wr_data   <= '0;
      commit_wr <= 1'b0;
      out_sh    <= '0;
      miso_oe   <= 1'b0;
    end else begin
      sclk_q    <= sclk_s;
      commit_wr <= 1'b0;
      if (!cs_act) begin
        bit_cnt   <= '0;
        sel_q     <= 1'b0;
        rd_q      <= 1'b0;
        load_pend <= 1'b0;
        miso_oe   <= 1'b0;
      end else begin
        if (rise && bit_cnt != FRAME_END) begin
          shreg   <= byte_now[BYTE_W-2:0];
          bit_cnt <= bit_cnt + 1'b1;
          if (bit_cnt == OP_LAST) begin
            sel_q  <= op_match;
            rd_q   <= op_now.rd;
            op_dev <= op_now.dev;
          end
          if (bit_cnt == ADDR_LAST) begin
            reg_addr  <= byte_now;
            load_pend <= 1'b1;
          end
          if (bit_cnt == DATA_LAST) begin
            wr_data   <= byte_now;
            commit_wr <= sel_q & ~rd_q;
          end
        end
        if (load_pend) begin
          load_pend <= 1'b0;
          out_sh    <= rd_data;
          miso_oe   <= sel_q & rd_q;
        end else if (fall && miso_oe && bit_cnt > SHIFT_MIN) begin
          out_sh <= {out_sh[BYTE_W-2:0], 1'b0};
        end
      end
    end
  end

  assign miso = out_sh[BYTE_W-1];
endmodule

// File: rtl/spi_gpio_regs.sv
module spi_gpio_regs
  import spi_gpio_pkg::*;
#(
  parameter int NUM_PORTS = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        commit_wr,
  input  logic [BYTE_W-1:0]           reg_addr,
  input  logic [BYTE_W-1:0]           wr_data,
  input  logic [NUM_PORTS*BYTE_W-1:0] pin_s,
  output logic [BYTE_W-1:0]           rd_data,
  output logic                        haen,
  output logic [NUM_PORTS*BYTE_W-1:0] gpio_out,
  output logic [NUM_PORTS*BYTE_W-1:0] gpio_oe
);
  logic [BYTE_W-1:0] port_rd [NUM_PORTS];
  logic [BYTE_W-1:0] cfg_rd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) haen <= 1'b0;
    else if (commit_wr && reg_addr == REG_CFG) haen <= wr_data[CFG_MATCH_BIT];
  end

  always_comb begin
    cfg_rd = '0;
    cfg_rd[CFG_MATCH_BIT] = haen;
  end

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    localparam logic [BYTE_W-1:0] DIR_ADDR = REG_DIR_BASE + BYTE_W'(p);
    localparam logic [BYTE_W-1:0] PIN_ADDR = REG_PIN_BASE + BYTE_W'(p);
    logic [BYTE_W-1:0] dir_q, lat_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        dir_q <= '1;
        lat_q <= '0;
      end else if (commit_wr) begin
        if (reg_addr == DIR_ADDR) dir_q <= wr_data;
        if (reg_addr == PIN_ADDR) lat_q <= wr_data;
      end
    end

    assign gpio_out[p*BYTE_W +: BYTE_W] = lat_q;
    assign gpio_oe[p*BYTE_W +: BYTE_W]  = ~dir_q;
    assign port_rd[p] = (reg_addr == DIR_ADDR) ? dir_q :
                        (reg_addr == PIN_ADDR) ? pin_s[p*BYTE_W +: BYTE_W] : '0;
  end

  always_comb begin
    rd_data = (reg_addr == REG_CFG) ? cfg_rd : '0;
    for (int p = 0; p < NUM_PORTS; p++) rd_data = rd_data | port_rd[p];
  end
endmodule

// File: rtl/spi_gpio_expander.sv
module spi_gpio_expander
  import spi_gpio_pkg::*;
#(
  parameter int NUM_PORTS   = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        spi_sclk,
  input  logic                        spi_cs_n,
  input  logic                        spi_mosi,
  output logic                        spi_miso,
  output logic                        spi_miso_oe,
  input  logic [DEV_W-1:0]            hw_addr,
  input  logic [NUM_PORTS*BYTE_W-1:0] gpio_in,
  output logic [NUM_PORTS*BYTE_W-1:0] gpio_out,
  output logic [NUM_PORTS*BYTE_W-1:0] gpio_oe
);
  localparam int PIN_W = NUM_PORTS * BYTE_W;

  logic              sclk_s, cs_n_s, mosi_s;
  logic [PIN_W-1:0]  pin_s;
  logic              cs_act, commit_wr, haen, miso_raw;
  logic [BYTE_W-1:0] reg_addr, wr_data, rd_data;
  logic [DEV_W-1:0]  op_dev;

  spi_gpio_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) u_bus_sync (
    .clk(clk), .rst_n(rst_n),
    .d({spi_sclk, spi_cs_n, spi_mosi}),
    .q({sclk_s, cs_n_s, mosi_s})
  );

  spi_gpio_sync #(.WIDTH(PIN_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_pin_sync (
    .clk(clk), .rst_n(rst_n), .d(gpio_in), .q(pin_s)
  );

  spi_gpio_frame u_frame (
    .clk(clk), .rst_n(rst_n),
    .sclk_s(sclk_s), .cs_n_s(cs_n_s), .mosi_s(mosi_s),
    .hw_addr(hw_addr), .haen(haen), .rd_data(rd_data),
    .cs_act(cs_act), .reg_addr(reg_addr), .wr_data(wr_data),
    .commit_wr(commit_wr), .op_dev(op_dev),
    .miso(miso_raw), .miso_oe(spi_miso_oe)
  );

  spi_gpio_regs #(.NUM_PORTS(NUM_PORTS)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .commit_wr(commit_wr), .reg_addr(reg_addr), .wr_data(wr_data),
    .pin_s(pin_s), .rd_data(rd_data), .haen(haen),
    .gpio_out(gpio_out), .gpio_oe(gpio_oe)
  );

  assign spi_miso = spi_miso_oe & miso_raw;
endmodule

// File: rtl/spi_gpio_expander_chk.sv
module spi_gpio_expander_chk #(
  parameter int PIN_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cs_act,
  input logic             spi_miso_oe,
  input logic             commit_wr,
  input logic             haen,
  input logic [2:0]       hw_addr,
  input logic [2:0]       op_dev,
  input logic [PIN_W-1:0] gpio_out,
  input logic [PIN_W-1:0] gpio_oe
);
  logic rst_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_prev <= 1'b0;
    else        rst_prev <= 1'b1;
  end

  assert_reset_state_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !rst_prev |-> (gpio_oe == '0 && gpio_out == '0 && !haen && !spi_miso_oe));

  assert_pins_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !commit_wr |=> ($stable(gpio_oe) && $stable(gpio_out) && $stable(haen)));

  assert_miso_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_act |=> !spi_miso_oe);

  assert_strap_match_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_miso_oe && haen) |-> op_dev == hw_addr);

  assert_default_dev_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_miso_oe && !haen) |-> op_dev == 3'b000);

  assert_no_drive_on_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
    commit_wr |-> !spi_miso_oe);
endmodule

bind spi_gpio_expander spi_gpio_expander_chk #(.PIN_W(PIN_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_act(cs_act), .spi_miso_oe(spi_miso_oe),
  .commit_wr(commit_wr), .haen(haen), .hw_addr(hw_addr), .op_dev(op_dev),
  .gpio_out(gpio_out), .gpio_oe(gpio_oe)
);

// File: tb/spi_gpio_expander_tb_top.sv
`timescale 1ns/1ps
module spi_gpio_expander_tb_top;
  localparam int HALF = 6;
  localparam int WD   = 190000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        spi_sclk = 1'b0, spi_cs_n = 1'b1, spi_mosi = 1'b0;
  logic        spi_miso, spi_miso_oe;
  logic [2:0]  strap = 3'b000;
  logic [15:0] ext = 16'h0000;
  logic [15:0] gpio_in, gpio_out, gpio_oe;

  int n_chk = 0, n_fail = 0;

  logic [7:0] m_dir [2];
  logic [7:0] m_lat [2];
  logic       m_haen;

  always #2 clk = ~clk;

  assign gpio_in = (gpio_out & gpio_oe) | (ext & ~gpio_oe);

  spi_gpio_expander dut_i (
    .clk(clk), .rst_n(rst_n),
    .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi),
    .spi_miso(spi_miso), .spi_miso_oe(spi_miso_oe),
    .hw_addr(strap), .gpio_in(gpio_in), .gpio_out(gpio_out), .gpio_oe(gpio_oe)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] m_read(input logic [7:0] ra);
    case (ra)
      8'h00:   return m_dir[0];
      8'h01:   return m_dir[1];
      8'h0B:   return {4'b0000, m_haen, 3'b000};
      8'h12:   return (m_lat[0] & ~m_dir[0]) | (ext[7:0] & m_dir[0]);
      8'h13:   return (m_lat[1] & ~m_dir[1]) | (ext[15:8] & m_dir[1]);
      default: return 8'h00;
    endcase
  endfunction

  function automatic bit m_sel(input logic [7:0] op);
    return op[7:4] == 4'b0100 && op[3:1] == (m_haen ? strap : 3'b000);
  endfunction

  task automatic xfer(input logic [7:0] op, input logic [7:0] ra, input logic [7:0] wd,
                      input int nbits, output logic [7:0] rx, output int oe_e, output int oe_l);
    logic [23:0] tx;
    tx = {op, ra, wd};
    rx = '0; oe_e = 0; oe_l = 0;
    spi_cs_n = 1'b0;
    repeat (HALF) @(posedge clk);
    for (int b = 0; b < nbits; b++) begin
      spi_mosi = tx[23-b];
      repeat (HALF) @(posedge clk);
      #1;
      if (spi_miso_oe) begin
        if (b < 16) oe_e++; else oe_l++;
      end
      if (b >= 16) rx = {rx[6:0], spi_miso};
      spi_sclk = 1'b1;
      repeat (HALF) @(posedge clk);
      #1;
      spi_sclk = 1'b0;
    end
    repeat (HALF) @(posedge clk);
    #1;
    spi_cs_n = 1'b1;
    repeat (4 * HALF) @(posedge clk);
    #1;
  endtask

  task automatic do_write(input logic [2:0] dev, input logic [7:0] ra, input logic [7:0] wd,
                          input string tag, input int nbits = 24, input logic [3:0] pre = 4'b0100);
    logic [7:0] op, rx;
    int oe_e, oe_l;
    bit sel;
    op  = {pre, dev, 1'b0};
    sel = m_sel(op);
    xfer(op, ra, wd, nbits, rx, oe_e, oe_l);
    check(oe_e + oe_l == 0, {"R11 write drove MISO (", tag, ")"}, oe_e + oe_l, 0);
    if (sel && nbits == 24) begin
      case (ra)
        8'h00: m_dir[0] = wd;
        8'h01: m_dir[1] = wd;
        8'h12: m_lat[0] = wd;
        8'h13: m_lat[1] = wd;
        8'h0B: m_haen   = wd[3];
        default: ;
      endcase
    end
  endtask

  task automatic do_read(input logic [2:0] dev, input logic [7:0] ra, input string tag,
                         input logic [3:0] pre = 4'b0100);
    logic [7:0] op, rx, exp;
    int oe_e, oe_l;
    bit sel;
    op  = {pre, dev, 1'b1};
    sel = m_sel(op);
    exp = m_read(ra);
    xfer(op, ra, 8'h00, 24, rx, oe_e, oe_l);
    if (sel) begin
      check(oe_e == 0 && oe_l == 8, {"R11 drive window (", tag, ")"}, {oe_e[15:0], oe_l[15:0]}, 32'h0000_0008);
      check(rx == exp, {tag, " readback"}, rx, exp);
    end else begin
      check(oe_e + oe_l == 0, {"R9 unselected drive (", tag, ")"}, oe_e + oe_l, 0);
    end
  endtask

  task automatic check_ports(input string tag);
    check(gpio_oe == {~m_dir[1], ~m_dir[0]}, {tag, " output enables"}, gpio_oe, {~m_dir[1], ~m_dir[0]});
    check(gpio_out == {m_lat[1], m_lat[0]}, {tag, " latch values"}, gpio_out, {m_lat[1], m_lat[0]});
  endtask

  initial begin
    repeat (WD) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog R3: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    m_dir[0] = 8'hFF; m_dir[1] = 8'hFF;
    m_lat[0] = 8'h00; m_lat[1] = 8'h00;
    m_haen   = 1'b0;
    repeat (10) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (5) @(posedge clk);
    #1;

    // R1: reset state at the ports and through readback
    check(gpio_oe == 16'h0000, "R1 pins released", gpio_oe, 0);
    check(gpio_out == 16'h0000, "R1 latches clear", gpio_out, 0);
    check(spi_miso_oe == 1'b0, "R1 MISO idle", spi_miso_oe, 0);
    do_read(3'd0, 8'h00, "R1 dir A");
    do_read(3'd0, 8'h01, "R1 dir B");
    do_read(3'd0, 8'h0B, "R1 cfg");

    // R6: matching disabled, straps ignored, only device 000 answers
    strap = 3'b101;
    for (int d = 0; d < 8; d++) begin
      do_read(3'(d), 8'h00, "R6 read");
      do_write(3'(d), 8'h00, 8'hA0 | 8'(d), "R6 write");
      do_read(3'd0, 8'h00, "R6 confirm");
      check_ports("R4 after R6 write");
    end

    // R3 R4 R5: direction and latch patterns on both ports
    for (int i = 0; i < 8; i++) begin
      logic [7:0] pa, pb;
      pa  = 8'(i * 37 + 11);
      pb  = 8'(i * 91 + 200);
      ext = 16'(i * 4099 + 16'h3C5A);
      do_write(3'd0, 8'h00, pa, "R4 dir A");
      do_write(3'd0, 8'h12, ~pa ^ 8'(i), "R4 latch A");
      do_write(3'd0, 8'h01, pb, "R4 dir B");
      do_write(3'd0, 8'h13, pb ^ 8'h5A, "R4 latch B");
      check_ports("R4 pattern");
      do_read(3'd0, 8'h00, "R3 dir A");
      do_read(3'd0, 8'h01, "R3 dir B");
      do_read(3'd0, 8'h12, "R5 pins A");
      do_read(3'd0, 8'h13, "R5 pins B");
    end

    // R10: unmapped addresses and unused configuration bits
    do_write(3'd0, 8'h05, 8'h3C, "R10 unmapped write");
    do_write(3'd0, 8'h0B, 8'hF7, "R10 cfg other bits");
    do_read(3'd0, 8'h0B, "R10 cfg");
    do_read(3'd0, 8'h05, "R10 unmapped read");
    do_read(3'd0, 8'h14, "R10 unmapped read hi");
    do_read(3'd0, 8'h00, "R10 dir A kept");
    do_read(3'd0, 8'h13, "R10 pins B kept");
    check_ports("R10 ports kept");

    // R2: wrong opcode prefix is ignored
    do_write(3'd0, 8'h00, 8'h3C, "R2 bad prefix", 24, 4'b0110);
    do_read(3'd0, 8'h00, "R2 bad prefix read", 4'b1100);
    do_read(3'd0, 8'h00, "R2 dir A kept");
    check_ports("R2 ports kept");

    // R8: aborted frames
    for (int k = 0; k < 3; k++) begin
      int n;
      n = (k == 0) ? 8 : (k == 1) ? 16 : 23;
      do_write(3'd0, 8'h01, 8'h5A, "R8 abort", n);
      do_read(3'd0, 8'h01, "R8 dir B kept");
      check_ports("R8 ports kept");
    end

    // R7: enable matching, then sweep strap against device number
    do_write(3'd0, 8'h0B, 8'h08, "R7 enable match");
    do_read(3'd0, 8'h00, "R7 dev0 silent");
    for (int s = 0; s < 8; s++) begin
      strap = 3'(s);
      repeat (4) @(posedge clk);
      #1;
      for (int d = 0; d < 8; d++) do_read(3'(d), 8'h01, "R7 sweep");
      do_write(3'(s) ^ 3'b001, 8'h13, 8'(s), "R7 mismatch write");
      do_write(3'(s), 8'h12, 8'(s * 9), "R7 match write");
      check_ports("R7 ports");
      do_read(3'(s), 8'h0B, "R7 cfg");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule